// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides, one bus cycle at a time, who owns a shared bus. The candidates are the CPU, which is the default owner, two DMA channels and a DRAM refresh requester. Each channel is armed by a configuration load that gives it a start address, a transfer count and a sensing mode. A request then comes from the channel's active-low request pin. While a channel owns the bus it makes one transfer per cycle. Each transfer presents the channel's current address, and the address then steps up by one and the count down by one. The burst ends when the count is used up.

The pins are synchronised with two flip-flops. In edge mode a falling edge latches the channel's request bit, and the bit holds until the burst completes. In level mode the request bit is the synchronised pin level itself. Releasing the pin pauses the burst and gives the bus back to the CPU. The enable bit and the address are kept, so pulling the pin low again resumes the burst at the next address.

Channel 0 wins over channel 1 when both are ready. A running burst is never taken over by the other channel. After any burst ends, the CPU holds the bus for at least one cycle. A refresh request beats both channels and may cut into a burst for one cycle, after which the burst carries on.

The bus state machine has four states: `OWN_CPU`, `OWN_DMA0`, `OWN_DMA1` and `OWN_REFR`. Its transitions are:

- CPU→REFR: refresh is pending.
- CPU→DMA0: channel 0 is ready.
- CPU→DMA1: only channel 1 is ready.
- DMAi→CPU: the burst completes (last transfer), or the channel's request bit drops (pause).
- DMAi→REFR: refresh is pending and the current transfer is not the last.
- REFR→DMAi: the interrupted channel is still ready.
- REFR→CPU: no channel was interrupted, or the interrupted channel is no longer ready.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset `bus_owner` is 0 and both `chan_en` and `chan_req` bits are 0. The owner codes are 0 = CPU, 1 = channel 0, 2 = channel 1 and 3 = refresh.
- R2: With the channel idle and the CPU owning the bus, a pin falling at a clock's active edge gives the bus to the channel on the 3rd edge after it in level mode (`cfg_level`=1). In edge mode (`cfg_level`=0) this happens on the 4th edge.
- R3: In edge mode a falling pin edge sets the request bit, and the bit stays 1 after the pin returns high. Completing the burst clears both the request bit and the enable bit.
- R4: In level mode the request bit is 1 exactly while the synchronised pin is low. It stays 1 after the burst completes for as long as the pin stays low.
- R5: A granted channel makes one transfer per cycle. `xfer_addr` starts at the loaded address and rises by one per transfer, wrapping at the top of the address space. After exactly the loaded count of transfers the bus returns to the CPU.
- R6: If a level-mode pin goes high mid-burst, the bus goes back to the CPU within three cycles and the enable bit stays 1. A later low level resumes the burst at the address after the last one transferred.
- R7: When both channels are ready while the CPU owns the bus, channel 0 is granted first.
- R8: A burst in progress is never taken over by the other channel. Between the bursts of two channels the CPU owns the bus for at least one cycle.
- R9: A refresh request is granted ahead of both channels, for one cycle, on the next edge. When it cuts into a burst, the interrupted channel resumes at its next address.
- R10: A load with a zero count leaves the channel disabled, so its requests never take the bus. A load is ignored in a cycle where that channel is transferring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bus cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 2 | Active-low request pins, one per channel |
| refresh_req | input | 1 | DRAM refresh request, held until granted |
| cfg_load | input | 2 | Load strobe per channel |
| cfg_level | input | 1 | Mode for the load: 1 level sense, 0 edge sense |
| cfg_addr | input | AW | Start address for the load |
| cfg_count | input | CW | Transfer count for the load |
| bus_owner | output | 2 | Current owner: 0 CPU, 1 channel 0, 2 channel 1, 3 refresh |
| xfer_addr | output | AW | Address of the current DMA transfer, 0 when no channel owns the bus |
| chan_en | output | 2 | Enable bit per channel |
| chan_req | output | 2 | Request bit per channel |

## Verification
Each result has a fixed due cycle after its stimulus. A level-mode pin change reaches the request bit two edges later and the owner three edges later; an edge-mode request reaches the request bit three edges later and the owner four edges later. A refresh request, or a ready channel seen while the CPU owns the bus, changes the owner on the very next edge. The bench drives every stimulus on a falling clock edge and advances one falling edge at a time, comparing the owner and address on the exact cycle these latencies predict. Each burst is traced transfer by transfer, so that a pause, a refresh slot or a CPU gap shows up as a specific cycle with a specific owner.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        OWN_CPU  = 2'd0,
        OWN_DMA0 = 2'd1,
        OWN_DMA1 = 2'd2,
        OWN_REFR = 2'd3
    } owner_e;

endpackage

// File: rtl/dma_req_sense.sv
module dma_req_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic level_mode,
    input  logic clr,
    output logic pin_low,
    output logic req_bit
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         prev_q;
    logic         latch_q;
    logic         fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[TOP-1:0], req_n};
            prev_q <= sync_q[TOP];
        end
    end

    assign pin_low = ~sync_q[TOP];
    assign fall    = ~sync_q[TOP] & prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    latch_q <= 1'b0;
        else if (clr)  latch_q <= 1'b0;
        else if (fall) latch_q <= 1'b1;
    end

    assign req_bit = level_mode ? pin_low : latch_q;

    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && latch_q && !clr) |=> latch_q); // R3

    AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !latch_q); // R3

endmodule

// File: rtl/dma_chan_ctr.sv
module dma_chan_ctr #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_level,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_count,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic          en_q,
    output logic          level_q,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            en_q    <= 1'b0;
            level_q <= 1'b0;
        end else if (load) begin
            addr_q  <= load_addr;
            cnt_q   <= load_count;
            en_q    <= |load_count;
            level_q <= load_level;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) en_q <= 1'b0;
        end
    end

    assign last = (cnt_q == CW'(1));

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> addr_q == $past(addr_q) + AW'(1)); // R5

    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !step && !load) |=> en_q); // R6

    AST_STEP_EN: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> en_q); // R10

endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
    import dma_arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ready,
    input  logic [NCH-1:0] last,
    input  logic           refresh_req,
    output owner_e         owner,
    output logic [NCH-1:0] step
);

    owner_e state_q, state_d;
    logic   ret_valid_q, ret_valid_d;
    logic   ret_ch_q, ret_ch_d;
    logic   cur_ch;

    assign cur_ch = (state_q == OWN_DMA1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= OWN_CPU;
            ret_valid_q <= 1'b0;
            ret_ch_q    <= 1'b0;
        end else begin
            state_q     <= state_d;
            ret_valid_q <= ret_valid_d;
            ret_ch_q    <= ret_ch_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        ret_valid_d = ret_valid_q;
        ret_ch_d    = ret_ch_q;
        unique case (state_q)
            OWN_CPU: begin
                if (refresh_req) begin
                    state_d     = OWN_REFR;
                    ret_valid_d = 1'b0;
                end else if (ready[0]) begin
                    state_d = OWN_DMA0;
                end else if (ready[1]) begin
                    state_d = OWN_DMA1;
                end
            end
            OWN_DMA0, OWN_DMA1: begin
                if (last[cur_ch]) begin
                    state_d = OWN_CPU;
                end else if (refresh_req) begin
                    state_d     = OWN_REFR;
                    ret_valid_d = 1'b1;
                    ret_ch_d    = cur_ch;
                end else if (!ready[cur_ch]) begin
                    state_d = OWN_CPU;
                end
            end
            OWN_REFR: begin
                ret_valid_d = 1'b0;
                if (ret_valid_q && ready[ret_ch_q])
                    state_d = ret_ch_q ? OWN_DMA1 : OWN_DMA0;
                else
                    state_d = OWN_CPU;
            end
            default: state_d = OWN_CPU;
        endcase
    end

    always_comb begin
        owner   = state_q;
        step[0] = (state_q == OWN_DMA0);
        step[1] = (state_q == OWN_DMA1);
    end

    AST_CPU_GAP_01: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_DMA0) |=> (state_q != OWN_DMA1)); // R8

    AST_CPU_GAP_10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_DMA1) |=> (state_q != OWN_DMA0)); // R8

    AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_CPU && refresh_req) |=> (state_q == OWN_REFR)); // R9

    AST_CH0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_CPU && !refresh_req && ready[0]) |=> (state_q == OWN_DMA0)); // R7

    AST_REFR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_REFR) |=> (state_q != OWN_REFR)); // R9

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int AW          = 16,
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    req_n,
    input  logic          refresh_req,
    input  logic [1:0]    cfg_load,
    input  logic          cfg_level,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    output logic [1:0]    bus_owner,
    output logic [AW-1:0] xfer_addr,
    output logic [1:0]    chan_en,
    output logic [1:0]    chan_req
);

    owner_e         owner_w;
    logic [NCH-1:0] step_w;
    logic [NCH-1:0] last_w;
    logic [NCH-1:0] ready_w;
    logic [NCH-1:0] level_w;
    logic [NCH-1:0] pin_low_w;
    logic [AW-1:0]  addr_w [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic load_ok;
        logic clr;

        assign load_ok = cfg_load[ch] & ~step_w[ch];
        assign clr     = load_ok | (step_w[ch] & last_w[ch]);

        dma_chan_ctr #(.AW(AW), .CW(CW)) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_ok),
            .load_level (cfg_level),
            .load_addr  (cfg_addr),
            .load_count (cfg_count),
            .step       (step_w[ch]),
            .addr_q     (addr_w[ch]),
            .en_q       (chan_en[ch]),
            .level_q    (level_w[ch]),
            .last       (last_w[ch])
        );

        dma_req_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_n      (req_n[ch]),
            .level_mode (level_w[ch]),
            .clr        (clr),
            .pin_low    (pin_low_w[ch]),
            .req_bit    (chan_req[ch])
        );

        assign ready_w[ch] = chan_en[ch] & chan_req[ch];

        AST_LEVEL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
            (level_w[ch] && pin_low_w[ch]) |-> chan_req[ch]); // R4
    end

    dma_bus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready       (ready_w),
        .last        (last_w),
        .refresh_req (refresh_req),
        .owner       (owner_w),
        .step        (step_w)
    );

    assign bus_owner = owner_w;
    assign xfer_addr = step_w[1] ? addr_w[1] : (step_w[0] ? addr_w[0] : '0);

    AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_owner == 2'd0 || bus_owner == 2'd3) |-> (xfer_addr == '0)); // R5

endmodule

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;

    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    req_n = 2'b11;
    logic          refresh_req = 1'b0;
    logic [1:0]    cfg_load = 2'b00;
    logic          cfg_level = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    bus_owner;
    logic [AW-1:0] xfer_addr;
    logic [1:0]    chan_en;
    logic [1:0]    chan_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_bus_arbiter #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .refresh_req(refresh_req),
        .cfg_load(cfg_load), .cfg_level(cfg_level), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .bus_owner(bus_owner), .xfer_addr(xfer_addr),
        .chan_en(chan_en), .chan_req(chan_req)
    );

    // {channel, level mode, start address, count}
    localparam logic [25:0] VEC [4] = '{
        {1'b0, 1'b0, 16'h0010, 8'd3},
        {1'b1, 1'b0, 16'h00F0, 8'd5},
        {1'b0, 1'b1, 16'h1234, 8'd4},
        {1'b1, 1'b1, 16'hFFFE, 8'd3}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic own(input int exp, input string tag);
        chk(bus_owner == 2'(exp), tag, int'(bus_owner), exp);
    endtask

    task automatic own_addr(input int exp_o, input int exp_a, input string tag);
        own(exp_o, tag);
        chk(xfer_addr == AW'(exp_a), tag, int'(xfer_addr), exp_a);
    endtask

    task automatic load(input int ch, input bit lvl, input int addr, input int cnt);
        cfg_level = lvl;
        cfg_addr  = AW'(addr);
        cfg_count = CW'(cnt);
        cfg_load  = 2'b00;
        cfg_load[ch] = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(2);
        // R1: reset state
        own(0, "R1 owner after reset");
        chk(chan_en == 2'b00, "R1 enable after reset", int'(chan_en), 0);
        chk(chan_req == 2'b00, "R1 request after reset", int'(chan_req), 0);
        rst_n = 1'b1;
        tick(2);
        own(0, "R1 owner idle");

        // Table walk: one complete burst per entry (R2, R3, R4, R5)
        for (int v = 0; v < 4; v++) begin
            int ch, st, cnt, lat;
            bit lvl;
            ch  = int'(VEC[v][25]);
            lvl = VEC[v][24];
            st  = int'(VEC[v][23:8]);
            cnt = int'(VEC[v][7:0]);
            lat = lvl ? 3 : 4;
            load(ch, lvl, st, cnt);
            req_n[ch] = 1'b0;
            for (int i = 1; i < lat; i++) begin
                tick();
                cfg_load = 2'b00;
                if (!lvl) req_n[ch] = 1'b1;
                own(0, "R2 no grant before latency");
            end
            if (lvl) chk(chan_req[ch] == 1'b1, "R4 request follows low pin", int'(chan_req[ch]), 1);
            else     chk(chan_req[ch] == 1'b1, "R3 request held with pin high", int'(chan_req[ch]), 1);
            for (int k = 0; k < cnt; k++) begin
                tick();
                own_addr(ch + 1, (st + k) & 16'hFFFF, "R5 burst transfer");
            end
            tick();
            own(0, "R5 bus back to CPU");
            chk(chan_en[ch] == 1'b0, "R3 enable cleared at completion", int'(chan_en[ch]), 0);
            if (lvl) chk(chan_req[ch] == 1'b1, "R4 request stays while pin low", int'(chan_req[ch]), 1);
            else     chk(chan_req[ch] == 1'b0, "R3 request cleared at completion", int'(chan_req[ch]), 0);
            req_n[ch] = 1'b1;
            tick(3);
            chk(chan_req[ch] == 1'b0, "R4 request drops with pin high", int'(chan_req[ch]), 0);
        end

        // R7 and R8: both channels requesting together
        load(0, 1'b0, 16'h0100, 2);
        tick();
        load(1, 1'b0, 16'h0200, 2);
        req_n = 2'b00;
        tick();
        cfg_load = 2'b00;
        req_n = 2'b11;
        tick(2);
        own(0, "R7 idle before grant");
        tick(); own_addr(1, 16'h0100, "R7 channel 0 first");
        tick(); own_addr(1, 16'h0101, "R7 channel 0 second");
        tick(); own(0, "R8 CPU gap between bursts");
        tick(); own_addr(2, 16'h0200, "R8 channel 1 after gap");
        tick(); own_addr(2, 16'h0201, "R8 channel 1 second");
        tick(); own(0, "R8 CPU after channel 1");
        tick(3);

        // R8: channel 0 arrives during a channel 1 burst
        load(0, 1'b0, 16'h0300, 1);
        tick();
        load(1, 1'b1, 16'h0400, 4);
        req_n[1] = 1'b0;
        tick();
        cfg_load = 2'b00;
        tick(2);
        own_addr(2, 16'h0400, "R8 channel 1 start");
        req_n[0] = 1'b0;
        tick(); own_addr(2, 16'h0401, "R8 no takeover 1");
        req_n[0] = 1'b1;
        tick(); own_addr(2, 16'h0402, "R8 no takeover 2");
        tick(); own_addr(2, 16'h0403, "R8 no takeover 3");
        tick(); own(0, "R8 CPU gap");
        tick(); own_addr(1, 16'h0300, "R8 channel 0 after gap");
        tick(); own(0, "R8 CPU after channel 0");
        req_n[1] = 1'b1;
        tick(3);

        // R6: level-mode pause and resume
        load(0, 1'b1, 16'h0040, 6);
        req_n[0] = 1'b0;
        tick();
        cfg_load = 2'b00;
        tick(2);
        own_addr(1, 16'h0040, "R6 first transfer");
        tick(); own_addr(1, 16'h0041, "R6 second transfer");
        req_n[0] = 1'b1;
        tick(); own_addr(1, 16'h0042, "R6 transfer in flight 1");
        tick(); own_addr(1, 16'h0043, "R6 transfer in flight 2");
        tick(); own(0, "R6 paused to CPU");
        chk(chan_en[0] == 1'b1, "R6 enable kept during pause", int'(chan_en[0]), 1);
        req_n[0] = 1'b0;
        tick(2);
        own(0, "R6 still paused");
        tick(); own_addr(1, 16'h0044, "R6 resume at next address");
        tick(); own_addr(1, 16'h0045, "R6 last transfer");
        tick(); own(0, "R6 done");
        chk(chan_req[0] == 1'b1, "R4 request stays after done", int'(chan_req[0]), 1);
        req_n[0] = 1'b1;
        tick(3);

        // R9: refresh while CPU owns the bus
        refresh_req = 1'b1;
        tick(); own(3, "R9 refresh granted from idle");
        refresh_req = 1'b0;
        tick(); own(0, "R9 CPU after refresh");

        // R9: refresh cutting into a burst
        load(1, 1'b0, 16'h0080, 4);
        req_n[1] = 1'b0;
        tick();
        cfg_load = 2'b00;
        req_n[1] = 1'b1;
        tick(3);
        own_addr(2, 16'h0080, "R9 burst start");
        refresh_req = 1'b1;
        tick(); own(3, "R9 refresh pre-empts burst");
        refresh_req = 1'b0;
        tick(); own_addr(2, 16'h0081, "R9 burst continues");
        tick(); own_addr(2, 16'h0082, "R9 burst continues 2");
        tick(); own_addr(2, 16'h0083, "R9 burst last");
        tick(); own(0, "R9 CPU after burst");
        tick(2);

        // R10: zero-count load keeps the channel off the bus
        load(0, 1'b1, 16'h0500, 0);
        req_n[0] = 1'b0;
        tick();
        cfg_load = 2'b00;
        for (int i = 0; i < 5; i++) begin
            tick();
            own(0, "R10 zero count never granted");
        end
        chk(chan_en[0] == 1'b0, "R10 enable stays clear", int'(chan_en[0]), 0);
        req_n[0] = 1'b1;
        tick(3);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule